// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a legacy PC peripheral combo device. It watches an 8-bit host I/O bus at two adjacent addresses: an index/key port at 0x3F0 and a data port at 0x3F1. Until a two-byte key of 0x55, 0x55 arrives at the index port, the block stays locked. In that state it only records the bytes written to the index port and ignores everything else. Once the key matches, the block is in configuration mode. Index-port writes then select a register, data-port writes update it and data-port reads return it. The exit byte 0xAA locks the block again.

The register contents are always available on a flat bus for the mapping logic downstream. Each accepted write that actually changes a register raises a one-cycle pulse for that register, together with a mask of the bits that flipped. Downstream logic can then rebuild only the functions that were touched. While configuration mode is active, a separate output tells the floppy controller to stop answering at 0x3F1, so the two functions do not both drive the data port.

Top module: `sio_cfg_port`

## Requirements
- R1: The block decodes the full 16-bit I/O address. Only 0x3F0 (index/key port) and 0x3F1 (data port) have any effect; writes to any other address, including aliases such as 0x13F0, 0x23F1 or 0x03F2, change nothing.
- R2: While locked, each write to 0x3F0 shifts its byte into a two-entry history. `cfg_active` goes high right after the clock edge that captures a write making both history entries 0x55. A 0x55 followed by any other byte does not enter.
- R3: While locked, writes to 0x3F1 are ignored: `cfg_regs` keeps its value and no change pulse is produced.
- R4: In configuration mode, writing 0xAA to 0x3F0 clears `cfg_active` after that edge. Any other byte written to 0x3F0, 0x55 included, becomes the current register index and leaves the mode active.
- R5: In configuration mode, a write to 0x3F1 stores its byte in the register selected by the current index when that index is below NREG (4 by default). Writes with an index of NREG or more change nothing.
- R6: `io_rdata` is registered and holds the result of the read strobe seen at the previous edge. A read of 0x3F1 in configuration mode returns the selected register, or 0x00 when the index is NREG or more. Every other read, and every cycle without a read strobe, gives 0xFF.
- R7: `fdc_data_block` rises at the same edge that enters configuration mode and falls at the same edge that leaves it.
- R8: Synchronous active-high reset clears the key history and the index to 0x00 and loads registers 0 to 3 with 0x3F, 0x9F, 0xDC and 0x78. Any further registers are loaded with 0x00.
- R9: An accepted data write that changes register i sets bit i of `reg_changed` for exactly one cycle after the edge, and `change_mask` equals the old value XOR the new value. A write of an equal value gives no pulse, and the mask is 0x00 whenever no pulse is present.
- R10: `cfg_regs` carries register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | AW (16) | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| cfg_active | output | 1 | Configuration mode is active |
| fdc_data_block | output | 1 | Tells the floppy controller not to answer at 0x3F1 |
| cfg_regs | output | NREG*8 | Flat view of all configuration registers |
| reg_changed | output | NREG | One-cycle pulse per register that changed value |
| change_mask | output | 8 | Bits that flipped in the register that changed |

## Verification
Every result in this block is due exactly one rising edge after the strobe that causes it:
- `cfg_active`, `fdc_data_block`, `cfg_regs`, `reg_changed`, `change_mask` and `io_rdata` all settle right after the edge that captures the write or read.
- The change pulse and mask last for that one cycle only.

The bench applies each strobe at a falling edge for a single cycle. It samples every output at the next falling edge, which falls between the capturing edge and the one after it. So every check sees the registered result of exactly one bus access. A reference model updates the expected key history, index and register values in the same order as the accesses.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int DW = 8;

  localparam logic [DW-1:0] KEY_BYTE    = 8'h55;
  localparam logic [DW-1:0] EXIT_BYTE   = 8'hAA;
  localparam logic [DW-1:0] IDLE_READ   = 8'hFF;
  localparam logic [DW-1:0] ABSENT_READ = 8'h00;

  // Power-on contents of each configuration register.
  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h3F;
      1:       return 8'h9F;
      2:       return 8'hDC;
      3:       return 8'h78;
      default: return 8'h00;
    endcase
  endfunction

  // True when the two history bytes form the unlock key.
  function automatic logic key_armed(input logic [DW-1:0] older,
                                     input logic [DW-1:0] newer);
    return (older == KEY_BYTE) && (newer == KEY_BYTE);
  endfunction

  // Bits that differ between the old and the new register value.
  function automatic logic [DW-1:0] change_mask_of(input logic [DW-1:0] old_v,
                                                   input logic [DW-1:0] new_v);
    return old_v ^ new_v;
  endfunction

endpackage

// File: rtl/sio_cfg_keytrack.sv
module sio_cfg_keytrack
  import sio_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  output logic          cfg_active,
  output logic          key_enter,
  output logic          key_exit,
  output logic          idx_load,
  output logic [DW-1:0] cur_index
);

  logic [DW-1:0] hist_old;
  logic [DW-1:0] hist_new;
  logic          hist_shift;

  assign cfg_active = key_armed(hist_old, hist_new);

  // Locked: every index write shifts. Active: only the exit byte shifts.
  assign hist_shift = idx_wr && (!cfg_active || (wdata == EXIT_BYTE));
  assign key_enter  = hist_shift && !cfg_active && key_armed(hist_new, wdata);
  assign key_exit   = hist_shift && cfg_active;
  assign idx_load   = idx_wr && cfg_active && (wdata != EXIT_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_old <= '0;
      hist_new <= '0;
    end else if (hist_shift) begin
      hist_old <= hist_new;
      hist_new <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cur_index <= '0;
    else if (idx_load) cur_index <= wdata;
  end

endmodule

// File: rtl/sio_cfg_regbank.sv
module sio_cfg_regbank
  import sio_cfg_pkg::*;
#(
  parameter int NREG = 4
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_idx,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [NREG-1:0]    chg_pulse,
  output logic [DW-1:0]      chg_mask
);

  logic [DW-1:0] regs_arr [NREG];
  logic [DW-1:0] sel_old;
  logic          sel_valid;
  logic          differs;

  // Current value of the addressed register, if it exists.
  always_comb begin
    sel_old   = '0;
    sel_valid = 1'b0;
    for (int k = 0; k < NREG; k++) begin
      if (wr_idx == DW'(k)) begin
        sel_old   = regs_arr[k];
        sel_valid = 1'b1;
      end
    end
  end

  assign differs = wr_en && sel_valid && (sel_old != wdata);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] value_q;
    logic          pulse_q;
    logic          hit;

    assign hit = wr_en && (wr_idx == DW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        value_q <= reg_default(i);
        pulse_q <= 1'b0;
      end else begin
        if (hit) value_q <= wdata;
        pulse_q <= hit && (value_q != wdata);
      end
    end

    assign regs_arr[i]            = value_q;
    assign regs_flat[i*DW +: DW]  = value_q;
    assign chg_pulse[i]           = pulse_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          chg_mask <= '0;
    else if (differs) chg_mask <= change_mask_of(sel_old, wdata);
    else              chg_mask <= '0;
  end

endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
  import sio_cfg_pkg::*;
#(
  parameter int NREG = 4
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [DW-1:0]      rd_idx,
  input  logic [NREG*DW-1:0] regs_flat,
  output logic [DW-1:0]      rdata
);

  logic [DW-1:0] sel_val;

  always_comb begin
    sel_val = ABSENT_READ;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == DW'(k)) sel_val = regs_flat[k*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= IDLE_READ;
    else if (rd_en) rdata <= sel_val;
    else            rdata <= IDLE_READ;
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] IDX_ADDR = 16'h03F0,
  parameter int            NREG     = 4
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               cfg_active,
  output logic               fdc_data_block,
  output logic [NREG*8-1:0]  cfg_regs,
  output logic [NREG-1:0]    reg_changed,
  output logic [7:0]         change_mask
);

  localparam logic [AW-1:0] DATA_ADDR = IDX_ADDR + 1'b1;

  // Named bus events, also observed by the checker.
  logic          idx_wr_hit;
  logic          data_wr_hit;
  logic          data_rd_hit;
  logic          key_enter;
  logic          key_exit;
  logic          idx_load;
  logic [DW-1:0] cur_index;
  logic          block_q;

  assign idx_wr_hit  = io_wr && (io_addr == IDX_ADDR);
  assign data_wr_hit = io_wr && (io_addr == DATA_ADDR);
  assign data_rd_hit = io_rd && (io_addr == DATA_ADDR);

  sio_cfg_keytrack u_key (
    .clk        (clk),
    .rst        (rst),
    .idx_wr     (idx_wr_hit),
    .wdata      (io_wdata),
    .cfg_active (cfg_active),
    .key_enter  (key_enter),
    .key_exit   (key_exit),
    .idx_load   (idx_load),
    .cur_index  (cur_index)
  );

  sio_cfg_regbank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (data_wr_hit && cfg_active),
    .wr_idx    (cur_index),
    .wdata     (io_wdata),
    .regs_flat (cfg_regs),
    .chg_pulse (reg_changed),
    .chg_mask  (change_mask)
  );

  sio_cfg_rdmux #(.NREG(NREG)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (data_rd_hit && cfg_active),
    .rd_idx    (cur_index),
    .regs_flat (cfg_regs),
    .rdata     (io_rdata)
  );

  // Floppy data-port takeover follows the key events.
  always_ff @(posedge clk) begin
    if (rst)            block_q <= 1'b0;
    else if (key_enter) block_q <= 1'b1;
    else if (key_exit)  block_q <= 1'b0;
  end

  assign fdc_data_block = block_q;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] IDX_ADDR = 16'h03F0,
  parameter int            NREG     = 4
)(
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_active,
  input logic              fdc_data_block,
  input logic [NREG*8-1:0] cfg_regs,
  input logic [NREG-1:0]   reg_changed,
  input logic [7:0]        change_mask,
  input logic              idx_wr_hit,
  input logic              data_wr_hit,
  input logic              key_enter
);

  localparam logic [AW-1:0] DATA_ADDR = IDX_ADDR + 1'b1;

  // R1
  foreign_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr != IDX_ADDR && io_addr != DATA_ADDR)
      |=> ($stable(cfg_regs) && $stable(cfg_active)));

  // R2
  key_enters_mode_chk: assert property (@(posedge clk) disable iff (rst)
    key_enter |=> cfg_active);

  // R3
  locked_data_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_active && data_wr_hit) |=> ($stable(cfg_regs) && reg_changed == '0));

  // R4
  exit_byte_locks_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_active && idx_wr_hit && io_wdata == 8'hAA) |=> !cfg_active);

  // R4
  index_write_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_active && idx_wr_hit && io_wdata != 8'hAA) |=> cfg_active);

  // R6
  idle_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!io_rd || !cfg_active) |=> (io_rdata == 8'hFF));

  // R7
  block_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
    fdc_data_block == cfg_active);

  // R9
  single_change_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_changed));

  // R9
  pulse_has_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_changed != '0) |-> (change_mask != 8'h00));

  // R9
  no_pulse_no_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_changed == '0) |-> (change_mask == 8'h00));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.AW(AW), .IDX_ADDR(IDX_ADDR), .NREG(NREG)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .io_addr        (io_addr),
  .io_wr          (io_wr),
  .io_rd          (io_rd),
  .io_wdata       (io_wdata),
  .io_rdata       (io_rdata),
  .cfg_active     (cfg_active),
  .fdc_data_block (fdc_data_block),
  .cfg_regs       (cfg_regs),
  .reg_changed    (reg_changed),
  .change_mask    (change_mask),
  .idx_wr_hit     (idx_wr_hit),
  .data_wr_hit    (data_wr_hit),
  .key_enter      (key_enter)
);

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        cfg_active;
  logic        fdc_data_block;
  logic [NREG*8-1:0] cfg_regs;
  logic [NREG-1:0]   reg_changed;
  logic [7:0]        change_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port dut_i (
    .clk            (clk),
    .rst            (rst),
    .io_addr        (io_addr),
    .io_wr          (io_wr),
    .io_rd          (io_rd),
    .io_wdata       (io_wdata),
    .io_rdata       (io_rdata),
    .cfg_active     (cfg_active),
    .fdc_data_block (fdc_data_block),
    .cfg_regs       (cfg_regs),
    .reg_changed    (reg_changed),
    .change_mask    (change_mask)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference model
  logic [7:0] m_old, m_new, m_idx;
  logic [7:0] m_regs [NREG];
  logic [NREG-1:0] e_pulse;
  logic [7:0]      e_mask;

  function automatic logic m_active();
    return (m_old == 8'h55) && (m_new == 8'h55);
  endfunction

  function automatic logic [NREG*8-1:0] m_flat();
    logic [NREG*8-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = m_regs[k];
    return f;
  endfunction

  function automatic logic [7:0] m_read(input logic [15:0] a);
    if (a == 16'h03F1 && m_active())
      return (m_idx < NREG) ? m_regs[m_idx] : 8'h00;
    return 8'hFF;
  endfunction

  task automatic m_reset();
    m_old = 8'h00; m_new = 8'h00; m_idx = 8'h00;
    m_regs[0] = 8'h3F; m_regs[1] = 8'h9F; m_regs[2] = 8'hDC; m_regs[3] = 8'h78;
  endtask

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    e_pulse = '0;
    e_mask  = 8'h00;
    if (a == 16'h03F0) begin
      if (!m_active() || d == 8'hAA) begin
        m_old = m_new; m_new = d;
      end else begin
        m_idx = d;
      end
    end else if (a == 16'h03F1 && m_active() && m_idx < NREG) begin
      if (m_regs[m_idx] != d) begin
        e_pulse[m_idx] = 1'b1;
        e_mask = m_regs[m_idx] ^ d;
      end
      m_regs[m_idx] = d;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " mode"}, 32'(cfg_active), 32'(m_active()));
    chk({tag, " R7 block"}, 32'(fdc_data_block), 32'(m_active()));
    chk({tag, " R10 regs"}, 32'(cfg_regs), 32'(m_flat()));
  endtask

  // Write strobe for one cycle; results are sampled at the next falling edge.
  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    m_write(a, d);
    chk_state(tag);
    chk({tag, " R9 pulse"}, 32'(reg_changed), 32'(e_pulse));
    chk({tag, " R9 mask"}, 32'(change_mask), 32'(e_mask));
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [7:0] exp_v;
    exp_v = m_read(a);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk({tag, " R6 rdata"}, 32'(io_rdata), 32'(exp_v));
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_reset();
    @(negedge clk);
    chk_state("R8 reset");
    chk("R8 rdata after reset", 32'(io_rdata), 32'hFF);
    chk("R8 no pulse", 32'(reg_changed), 32'h0);
  endtask

  logic [7:0] pats [5];

  initial begin
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h3C;
    m_reset();
    @(negedge clk);
    apply_reset();

    // R3 / R6: locked accesses to the data port
    do_read(16'h03F1, "R6 locked read");
    do_write(16'h03F1, 8'h00, "R3 locked data write");

    // R1: aliases of the ports do not feed the key history
    do_write(16'h03F0, 8'h12, "R1 prime");
    do_write(16'h13F0, 8'h55, "R1 alias 13F0");
    do_write(16'h23F0, 8'h55, "R1 alias 23F0");
    do_write(16'h03F2, 8'h55, "R1 addr 3F2");
    do_write(16'h23F1, 8'h55, "R1 alias 23F1");

    // R2: broken key, then a proper key
    do_write(16'h03F0, 8'h55, "R2 first key");
    do_write(16'h03F0, 8'h12, "R2 broken key");
    do_write(16'h03F0, 8'h55, "R2 restart key");
    do_write(16'h03F0, 8'h55, "R2 enter");
    do_read(16'h03F0, "R6 index port read");

    // R5 / R6 / R9: sweep indices and patterns
    for (int i = 0; i < 7; i++) begin
      for (int p = 0; p < 5; p++) begin
        do_write(16'h03F0, 8'(i), "R4 select");
        do_write(16'h03F1, pats[p], "R5 data write");
        do_read(16'h03F1, "R5 readback");
        do_write(16'h03F1, pats[p], "R9 same value");
      end
      do_write(16'h03F1, 8'(i * 37 + 1), "R5 computed value");
      do_read(16'h03F1, "R5 computed readback");
    end
    do_write(16'h03F0, 8'hFE, "R5 high index");
    do_write(16'h03F1, 8'h11, "R5 high index write");
    do_read(16'h03F1, "R6 absent read");

    // R4: 0x55 in config mode is an index, 0xAA exits
    do_write(16'h03F0, 8'h55, "R4 key byte as index");
    do_read(16'h03F1, "R4 index 55 read");
    do_write(16'h03F0, 8'h02, "R4 select 2");
    do_write(16'h03F0, 8'hAA, "R4 exit");
    do_read(16'h03F1, "R6 read after exit");
    do_write(16'h03F1, 8'h99, "R3 write after exit");
    do_write(16'h03F0, 8'h55, "R2 re-key 1");
    do_write(16'h03F0, 8'h55, "R2 re-key 2");
    do_read(16'h03F1, "R5 retained value");
    do_write(16'h03F1, 8'hC3, "R9 change after re-entry");

    // R8: reset from inside configuration mode
    apply_reset();
    do_read(16'h03F1, "R8 locked after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule